// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits on the controller side of a DDR2-style memory. It takes the command pins over whenever the memory must be put to sleep in self-refresh and brought back out. While the main scheduler owns the bus, the block drives deselect, keeps CKE high and ODT on, and holds `ready` high. When a power-down request arrives and every bank is idle, the block takes the following steps in order:

- It turns ODT off.
- If no auto-refresh has been issued since the last wake-up, it issues a precharge and then an auto-refresh.
- It issues the self-refresh entry command with CKE dropped.

A wake request raises CKE again, but only after two conditions hold: the minimum residency has passed and the clock-stable flag is set. The block then drives NOPs with ODT off for the full exit interval before it hands the bus back. Each exit clears the refresh-done flag, so the next entry must again be preceded by one extra auto-refresh. After reset the flag starts set, so the first entry may go straight in.

The timing rules are module parameters counted in clock cycles:

- `T_RP`: precharge to auto-refresh.
- `T_RFC`: auto-refresh to the next command.
- `T_CKE`: minimum self-refresh residency.
- `T_XSNR` and `T_XSRD`: the exit interval, whose enforced length `T_EXIT` is the larger of the two.

A single down-counter times all of them. It is reloaded on every state change.

Top module: `sr_sequencer`

## Requirements
Pin patterns are given as {cs_n, ras_n, cas_n, we_n}: deselect 1111, NOP 0111, precharge 0010, auto-refresh 0001 with CKE high, and self-refresh entry 0001 in the cycle CKE falls.

- R1: The block can be in reset, or back from reset while idle. In that state `ready`=1, `cke`=1, `odt`=1 and the pins show deselect (1111). Asserting reset forces this state at once, even in the middle of self-refresh.
- R2: In idle, a power-down request is ignored while `banks_idle` is low: `ready` and `cke` stay high.
- R3: The self-refresh entry cycle shows pins 0001 with `cke` low. `odt` is low in that cycle and in the cycle before it.
- R4: After reset, the first entry issues no precharge and no auto-refresh. The entry follows the ODT-off cycle by exactly 1 cycle. After any exit, the next entry is preceded by one precharge and one auto-refresh.
- R5: When a refresh is needed, the sequence is fixed. The precharge comes 1 cycle after the ODT-off cycle. The auto-refresh comes exactly `T_RP` cycles after the precharge. The entry comes exactly `T_RFC` cycles after the auto-refresh, with NOPs in between.
- R6: `cke` stays low for max(`T_CKE`, D+1) cycles. D is the number of cycles after the entry cycle at which `wake_req` and `clk_stable` are both first high. A wake without a stable clock does not end self-refresh.
- R7: From the cycle `cke` rises, the block drives `T_EXIT` cycles of NOP with `odt` low and `cke` high. `ready` then rises.
- R8: `ready` is low in every cycle from the ODT-off cycle until the exit interval ends, and high only in idle.
- R9: In idle, `wake_req` and `clk_stable` have no effect: `ready`, `cke` and `odt` stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_down_req | input | 1 | Request to enter self-refresh, sampled in idle |
| wake_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | External clock has restarted and is stable |
| banks_idle | input | 1 | All banks are precharged and idle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| odt | output | 1 | On-die termination enable |
| ready | output | 1 | Bus handed back to the main scheduler |

## Verification
The bench walks several wake patterns and measures every gap between precharge, auto-refresh, entry, CKE rise and the return of `ready`. A counter loaded one value off would show up as a gap that is one cycle long or short. A design that let the wake request through without the stable clock would raise CKE early in the vector where the clock settles late. The first entry after reset, and the entry after a reset taken in mid-sleep, must skip the refresh, while every later entry must include it; a refresh flag that is set or cleared wrongly breaks one of these. Any stray command or ODT pulse during the exit window is counted, as is any gap in `ready`.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ODT_OFF,
    ST_PRE,
    ST_RP_WAIT,
    ST_AREF,
    ST_RFC_WAIT,
    ST_SRE,
    ST_SR_HOLD,
    ST_EXIT_WAIT
  } sr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_pins_t;

  localparam dram_pins_t PINS_DESEL = 4'b1111;
  localparam dram_pins_t PINS_NOP   = 4'b0111;
  localparam dram_pins_t PINS_PRE   = 4'b0010;
  localparam dram_pins_t PINS_REF   = 4'b0001;

endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
  import sr_seq_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_RFC  = 8,
  parameter int T_CKE  = 4,
  parameter int T_EXIT = 12,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_down_req,
  input  logic          wake_req,
  input  logic          clk_stable,
  input  logic          banks_idle,
  input  logic          tmr_zero,
  output sr_state_e     state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  sr_state_e state_q;
  sr_state_e state_d;
  logic      refreshed_q;
  logic      refreshed_d;
  logic      refreshed_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (pwr_down_req && banks_idle) state_d = ST_ODT_OFF;
      ST_ODT_OFF:   state_d = refreshed_q ? ST_SRE : ST_PRE;
      ST_PRE:       state_d = ST_RP_WAIT;
      ST_RP_WAIT:   if (tmr_zero) state_d = ST_AREF;
      ST_AREF:      state_d = ST_RFC_WAIT;
      ST_RFC_WAIT:  if (tmr_zero) state_d = ST_SRE;
      ST_SRE:       state_d = ST_SR_HOLD;
      ST_SR_HOLD:   if (tmr_zero && wake_req && clk_stable) state_d = ST_EXIT_WAIT;
      ST_EXIT_WAIT: if (tmr_zero) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Each state lasts (reload value + 1) cycles; single-cycle states load zero.
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_RP_WAIT:   tmr_val = CW'(T_RP - 2);
      ST_RFC_WAIT:  tmr_val = CW'(T_RFC - 2);
      ST_SR_HOLD:   tmr_val = CW'(T_CKE - 2);
      ST_EXIT_WAIT: tmr_val = CW'(T_EXIT - 1);
      default:      tmr_val = '0;
    endcase
  end

  always_comb begin
    refreshed_en = (state_q == ST_AREF) ||
                   (state_q == ST_SR_HOLD && state_d == ST_EXIT_WAIT);
    refreshed_d  = (state_q == ST_AREF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refreshed_q <= 1'b1;
    end else if (refreshed_en) begin
      refreshed_q <= refreshed_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/sr_cmd_enc.sv
module sr_cmd_enc
  import sr_seq_pkg::*;
(
  input  sr_state_e  state,
  output dram_pins_t pins,
  output logic       cke,
  output logic       odt,
  output logic       ready
);

  always_comb begin
    unique case (state)
      ST_IDLE:       pins = PINS_DESEL;
      ST_PRE:        pins = PINS_PRE;
      ST_AREF,
      ST_SRE:        pins = PINS_REF;
      default:       pins = PINS_NOP;
    endcase
    cke   = !((state == ST_SRE) || (state == ST_SR_HOLD));
    odt   = (state == ST_IDLE);
    ready = (state == ST_IDLE);
  end

endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer
  import sr_seq_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_RFC  = 8,
  parameter int T_CKE  = 4,
  parameter int T_XSNR = 10,
  parameter int T_XSRD = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down_req,
  input  logic wake_req,
  input  logic clk_stable,
  input  logic banks_idle,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke,
  output logic odt,
  output logic ready
);

  localparam int T_EXIT = (T_XSNR > T_XSRD) ? T_XSNR : T_XSRD;
  localparam int T_M1   = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int T_M2   = (T_CKE > T_EXIT) ? T_CKE : T_EXIT;
  localparam int T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CW     = $clog2(T_MAX + 1);

  logic          rst_meta_q;
  logic          rst_sync_q;
  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  sr_state_e     state;
  dram_pins_t    pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sr_fsm #(
    .T_RP(T_RP), .T_RFC(T_RFC), .T_CKE(T_CKE), .T_EXIT(T_EXIT), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_q),
    .pwr_down_req(pwr_down_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .banks_idle(banks_idle),
    .tmr_zero(tmr_zero), .state(state),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sr_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_sync_q),
    .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sr_cmd_enc u_enc (
    .state(state), .pins(pins), .cke(cke), .odt(odt), .ready(ready)
  );

  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;

endmodule

// File: rtl/sr_seq_checker.sv
module sr_seq_checker #(
  parameter int T_RP   = 3,
  parameter int T_RFC  = 8,
  parameter int T_CKE  = 4,
  parameter int T_XSNR = 10,
  parameter int T_XSRD = 12
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_down_req,
  input logic wake_req,
  input logic clk_stable,
  input logic banks_idle,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic odt,
  input logic ready
);

  localparam int T_EXIT = (T_XSNR > T_XSRD) ? T_XSNR : T_XSRD;

  logic [3:0]  pins;
  logic        is_nop;
  logic        is_pre;
  logic        is_aref;
  logic [31:0] since_pre;
  logic [31:0] since_aref;
  logic [31:0] low_run;
  logic [31:0] high_run;
  logic        aref_armed;
  logic        exit_armed;
  logic        ref_seen;

  assign pins    = {cs_n, ras_n, cas_n, we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_pre  = (pins == 4'b0010) && cke;
  assign is_aref = (pins == 4'b0001) && cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre  <= '0;
      since_aref <= '0;
      low_run    <= '0;
      high_run   <= '0;
      aref_armed <= 1'b0;
      exit_armed <= 1'b0;
      ref_seen   <= 1'b1;
    end else begin
      since_pre  <= is_pre  ? 32'd1 : ((since_pre  != '1) ? since_pre  + 32'd1 : since_pre);
      since_aref <= is_aref ? 32'd1 : ((since_aref != '1) ? since_aref + 32'd1 : since_aref);
      low_run    <= cke ? '0 : ((low_run  != '1) ? low_run  + 32'd1 : low_run);
      high_run   <= !cke ? '0 : ((high_run != '1) ? high_run + 32'd1 : high_run);
      if (is_aref) aref_armed <= 1'b1;
      if (!cke)    exit_armed <= 1'b1;
      if (is_aref)      ref_seen <= 1'b1;
      else if (cke && low_run != '0) ref_seen <= 1'b0;
    end
  end

  a_r3_entry_odt_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (!odt && !$past(odt) && pins == 4'b0001));

  a_r4_refresh_before_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ref_seen);

  a_r5_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_aref |-> (since_pre >= 32'(T_RP)));

  a_r5_rfc_nops: assert property (@(posedge clk) disable iff (!rst_n)
    (aref_armed && since_aref < 32'(T_RFC)) |-> is_nop);

  a_r6_cke_residency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_run >= 32'(T_CKE)));

  a_r6_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(wake_req && clk_stable));

  a_r7_exit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && exit_armed && high_run < 32'(T_EXIT)) |-> (is_nop && !odt && !ready));

  a_r8_ready_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cke && odt && cs_n));

  a_r2_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !(pwr_down_req && banks_idle)) |=> ready);

endmodule

bind sr_sequencer sr_seq_checker #(
  .T_RP(T_RP), .T_RFC(T_RFC), .T_CKE(T_CKE), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down_req(pwr_down_req), .wake_req(wake_req),
  .clk_stable(clk_stable), .banks_idle(banks_idle), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .cke(cke), .odt(odt), .ready(ready)
);

// File: tb/tb_sr_sequencer.sv
module tb_sr_sequencer;

  localparam int T_RP   = 3;
  localparam int T_RFC  = 8;
  localparam int T_CKE  = 4;
  localparam int T_XSNR = 10;
  localparam int T_XSRD = 12;
  localparam int T_EXIT = (T_XSNR > T_XSRD) ? T_XSNR : T_XSRD;
  localparam int NVEC   = 5;
  // columns: wake delay, clock-stable delay, refresh expected before entry
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 0}, '{6, 2, 1}, '{2, 9, 1}, '{3, 3, 1}, '{4, 1, 1}
  };

  logic clk, rst_n, pwr_down_req, wake_req, clk_stable, banks_idle;
  logic cs_n, ras_n, cas_n, we_n, cke, odt, ready;

  int n_chk, n_fail, cyc;
  int first_low, pre_c, aref_c, sre_c, rise_c, ready_c, low_cnt, viol;
  logic odt_pre, odt_at, prev_cke, prev_odt, rec_on;

  sr_sequencer #(.T_RP(T_RP), .T_RFC(T_RFC), .T_CKE(T_CKE),
                 .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_down_req(pwr_down_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .banks_idle(banks_idle), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .odt(odt), .ready(ready));

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    first_low = -1; pre_c = -1; aref_c = -1; sre_c = -1;
    rise_c = -1; ready_c = -1; low_cnt = 0; viol = 0;
    odt_pre = 1'b1; odt_at = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rec_on) begin
      if (!ready && first_low < 0) first_low = cyc;
      if (!ready && ready_c < 0) low_cnt++;
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0010 && cke) pre_c = cyc;
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0001 && cke) aref_c = cyc;
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0001 && !cke && prev_cke) begin
        sre_c = cyc; odt_pre = prev_odt; odt_at = odt;
      end
      if (cke && !prev_cke) rise_c = cyc;
      if (ready && first_low >= 0 && ready_c < 0) ready_c = cyc;
      if (rise_c >= 0 && ready_c < 0 &&
          (!cke || odt || {cs_n, ras_n, cas_n, we_n} != 4'b0111)) viol++;
    end
    prev_cke = cke;
    prev_odt = odt;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic enter_sleep();
    clear_rec(); rec_on = 1'b1;
    step(); pwr_down_req = 1'b1; banks_idle = 1'b1;
    while (first_low < 0) step();
    pwr_down_req = 1'b0;
    while (sre_c < 0) step();
    clk_stable = 1'b0; wake_req = 1'b0;
  endtask

  task automatic run_vec(input int dw, input int ds, input int er);
    int d, exp_sleep, exp_entry;
    enter_sleep();
    while (rise_c < 0) begin
      step();
      if (cyc - sre_c >= dw) wake_req = 1'b1;
      if (cyc - sre_c >= ds) clk_stable = 1'b1;
    end
    wake_req = 1'b0;
    while (ready_c < 0) step();
    rec_on = 1'b0;
    d = (dw > ds) ? dw : ds;
    exp_sleep = (T_CKE > d + 1) ? T_CKE : d + 1;
    exp_entry = er ? (1 + T_RP + T_RFC) : 1;
    chk(!odt_pre && !odt_at, "R3 odt low before/at entry", {odt_pre, odt_at}, 0);
    if (er) begin
      chk(pre_c - first_low == 1, "R5 precharge after odt-off", pre_c - first_low, 1);
      chk(aref_c - pre_c == T_RP, "R5 precharge to refresh", aref_c - pre_c, T_RP);
      chk(sre_c - aref_c == T_RFC, "R5 refresh to entry", sre_c - aref_c, T_RFC);
    end else begin
      chk(pre_c < 0 && aref_c < 0, "R4 no refresh after reset", pre_c, -1);
    end
    chk(sre_c - first_low == exp_entry, "R4 entry position", sre_c - first_low, exp_entry);
    chk(rise_c - sre_c == exp_sleep, "R6 cke low residency", rise_c - sre_c, exp_sleep);
    chk(ready_c - rise_c == T_EXIT, "R7 exit interval", ready_c - rise_c, T_EXIT);
    chk(viol == 0, "R7 exit window nop/odt", viol, 0);
    chk(ready_c - first_low == low_cnt, "R8 ready low throughout", low_cnt, ready_c - first_low);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; rec_on = 1'b0;
    prev_cke = 1'b1; prev_odt = 1'b1;
    clear_rec();
    rst_n = 1'b0; pwr_down_req = 1'b0; wake_req = 1'b0;
    clk_stable = 1'b1; banks_idle = 1'b1;
    repeat (3) step();
    chk(ready && cke && odt && {cs_n, ras_n, cas_n, we_n} == 4'b1111,
        "R1 reset state", {ready, cke, odt, cs_n}, 4'b1111);
    rst_n = 1'b1;
    repeat (4) step();
    chk(ready && cke && odt && cs_n, "R1 idle after reset", {ready, cke, odt, cs_n}, 4'b1111);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R2: banks busy, request ignored
    begin
      int bad = 0;
      banks_idle = 1'b0; pwr_down_req = 1'b1;
      repeat (6) begin step(); if (!ready || !cke || !odt) bad++; end
      pwr_down_req = 1'b0; banks_idle = 1'b1;
      chk(bad == 0, "R2 busy banks block entry", bad, 0);
    end

    // R9: wake in idle has no effect
    begin
      int bad = 0;
      wake_req = 1'b1; clk_stable = 1'b1;
      repeat (6) begin step(); if (!ready || !cke || !odt) bad++; end
      wake_req = 1'b0;
      chk(bad == 0, "R9 wake ignored in idle", bad, 0);
    end

    // R1: reset taken during self-refresh
    enter_sleep();
    rec_on = 1'b0;
    rst_n = 1'b0; #1;
    chk(ready && cke && odt && {cs_n, ras_n, cas_n, we_n} == 4'b1111,
        "R1 async reset in sleep", {ready, cke, odt, cs_n}, 4'b1111);
    step(); rst_n = 1'b1; clk_stable = 1'b1;
    repeat (4) step();

    // R4: flag restored by reset, so no refresh on this entry
    run_vec(2, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule